// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block feeds an external stereo digital-to-analog converter over three wires. It takes a left/right pair of 16-bit samples from a producer and shifts both words out on one data line. The bit clock comes from outside the block and runs continuously at 32 times the sample rate, for example 1.4112 MHz at 44.1 kHz. Each 32-bit frame carries the left word and then the right word, each most significant bit first, with no idle bits between them. A channel strobe tells the converter which channel is being sent. A separate active-low control line asks the converter for 12 dB of attenuation.

The block runs on a fast system clock. It samples the external bit clock through a synchronizer and acts on each falling bit-clock edge, so that the data and strobe are settled before the converter samples them on the rising edge.

Samples enter through a valid/ready interface that has a single stereo-pair holding register behind it:
- `smp_ready` is high exactly when that register is empty.
- A pair is taken in any cycle where `smp_valid` and `smp_ready` are both high.
- The producer must hold its pair and `smp_valid` steady while `smp_ready` is low.
- The register is freed at the start of the frame that transmits the pair, so the producer has a whole frame to refill it.

A one-cycle request pulse marks the start of every word, which lets a feeder pace itself. If the register is empty when a frame starts, the frame carries zeros and a sticky underrun flag is set.

Top module: `sdac_tx`

## Requirements
- R1: After reset `ser_data`, `chan_sel`, `word_req` and `underrun` are 0, `atten_n` is 1 and `smp_ready` is 1.
- R2: A frame is 32 bit clocks with no gaps. The left word goes out first and then the right word, each as 16 bits, most significant bit first. One bit is sent per falling edge of `bit_clk`.
- R3: `chan_sel` is 0 for all 16 bits of the left word and 1 for all 16 bits of the right word. It changes on the same falling edge as the first bit of each word.
- R4: `ser_data` and `chan_sel` change only in response to a falling edge of `bit_clk`. They settle within 3 system-clock cycles of that edge and then hold until the next falling edge.
- R5: The holding register stores one stereo pair. While it is full, `smp_ready` is 0 and the stored pair is kept unchanged. It is freed only at the start of the frame that transmits it.
- R6: `word_req` pulses high for exactly one system-clock cycle at the start of each transmitted word, which gives two pulses per frame.
- R7: If the holding register is empty when a frame starts, both words of that frame are all zeros and `underrun` goes to 1. `underrun` then stays 1 until reset.
- R8: When `tx_en` goes low during a frame, the frame still completes. After that, `ser_data` and `chan_sel` stay 0, no `word_req` pulses occur, and a pending pair stays held.
- R9: `atten_n` is the inverse of `atten_req`, registered one system-clock cycle later. A 0 on `atten_n` requests 12 dB of attenuation.
- R10: While the block is idle, a frame starts on the first falling edge of `bit_clk` at which `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | External continuous serial bit clock |
| tx_en | input | 1 | Transmit enable |
| atten_req | input | 1 | Attenuation request bit |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Holding register can accept a pair |
| smp_left | input | 16 | Left-channel sample |
| smp_right | input | 16 | Right-channel sample |
| ser_data | output | 1 | Serial data to the converter |
| chan_sel | output | 1 | Channel strobe, 0 for left and 1 for right |
| atten_n | output | 1 | Active-low attenuation control |
| word_req | output | 1 | One-cycle pulse at each word start |
| underrun | output | 1 | Sticky flag: a frame started with no pair held |

## Verification
A falling edge of `bit_clk` reaches `ser_data` and `chan_sel` on the third system-clock edge after it: two synchronizer stages and then the output register. The bench holds each bit-clock phase for six system cycles and reads the data and strobe just before it raises the bit clock, which is the converter's own sample point. `word_req` pulses are counted over whole frames rather than timed. `atten_n` is checked two cycles after `atten_req` changes. Holding-register state is read through `smp_ready` and the producer's handshake count between frames, and underrun is read from its flag after each frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_WORD_W = 16;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  output logic fall_o
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], sck_i};
  end

  assign fall_o = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_left_i,
  input  logic [WORD_W-1:0] in_right_i,
  input  logic              consume_i,
  output logic              full_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  logic              full_q;
  logic [WORD_W-1:0] left_q, right_q;
  logic              take;

  assign take       = in_valid_i && !full_q;
  assign in_ready_o = !full_q;
  assign full_o     = full_q;
  assign left_o     = left_q;
  assign right_o    = right_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (take) begin
      full_q  <= 1'b1;
      left_q  <= in_left_i;
      right_q <= in_right_i;
    end else if (consume_i) begin
      full_q  <= 1'b0;
    end
  end

  // R5: a held pair survives until the shifter takes it
  assert_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !consume_i) |=> (full_q && $stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              enable_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              consume_o,
  output logic              sd_o,
  output logic              ws_o,
  output logic              word_req_o,
  output logic              underrun_o
);
  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q, rhold_q;
  chan_e             ws_q;
  logic              sd_q, req_q, unr_q;
  logic              last_bit, start_frame;

  assign last_bit    = (cnt_q == CNT_W'(FRAME_BITS - 1));
  assign start_frame = fall_i && enable_i && (!active_q || last_bit);
  assign consume_o   = start_frame && full_i;

  assign sd_o       = sd_q;
  assign ws_o       = ws_q;
  assign word_req_o = req_q;
  assign underrun_o = unr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      rhold_q  <= '0;
      ws_q     <= CH_LEFT;
      sd_q     <= 1'b0;
      req_q    <= 1'b0;
      unr_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (start_frame) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        ws_q     <= CH_LEFT;
        req_q    <= 1'b1;
        if (full_i) begin
          sd_q    <= left_i[WORD_W-1];
          shreg_q <= {left_i[WORD_W-2:0], 1'b0};
          rhold_q <= right_i;
        end else begin
          sd_q    <= 1'b0;
          shreg_q <= '0;
          rhold_q <= '0;
          unr_q   <= 1'b1;
        end
      end else if (fall_i && active_q && last_bit) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        ws_q     <= CH_LEFT;
        sd_q     <= 1'b0;
      end else if (fall_i && active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          ws_q    <= CH_RIGHT;
          req_q   <= 1'b1;
          sd_q    <= rhold_q[WORD_W-1];
          shreg_q <= {rhold_q[WORD_W-2:0], 1'b0};
        end else begin
          sd_q    <= shreg_q[WORD_W-1];
          shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  // R4: line levels move only after a detected falling bit-clock edge
  assert_lines_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> ($stable(sd_q) && $stable(ws_q)));
  // R6: a word request always follows a falling edge
  assert_req_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(fall_i));
  // R7: underrun is sticky
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unr_q |=> unr_q);
  // R3: the strobe rises only together with a word start
  assert_ws_rise_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws_q) |-> req_q);
  // R5: a pair is taken only when the holding register is full
  assert_consume_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    consume_o |-> full_i);
endmodule

// File: rtl/sdac_tx.sv
module sdac_tx #(
  parameter int WORD_W      = sdac_pkg::DEF_WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              tx_en,
  input  logic              atten_req,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  output logic              ser_data,
  output logic              chan_sel,
  output logic              atten_n,
  output logic              word_req,
  output logic              underrun
);
  logic              fall, full, consume;
  logic [WORD_W-1:0] held_l, held_r;
  logic              atten_n_q;

  sdac_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sck_i(bit_clk), .fall_o(fall)
  );

  sdac_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(smp_valid), .in_ready_o(smp_ready),
    .in_left_i(smp_left), .in_right_i(smp_right),
    .consume_i(consume), .full_o(full),
    .left_o(held_l), .right_o(held_r)
  );

  sdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .enable_i(tx_en),
    .full_i(full), .left_i(held_l), .right_i(held_r),
    .consume_o(consume), .sd_o(ser_data), .ws_o(chan_sel),
    .word_req_o(word_req), .underrun_o(underrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) atten_n_q <= 1'b1;
    else        atten_n_q <= ~atten_req;
  end
  assign atten_n = atten_n_q;

  // R9: control line follows the request bit one cycle later
  assert_atten_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (atten_n == !$past(atten_req)));
endmodule

// File: tb/sdac_tx_tb.sv
module sdac_tx_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk = 1'b1;
  logic tx_en = 1'b0;
  logic atten_req = 1'b0;
  logic smp_valid, smp_ready;
  logic [15:0] smp_left, smp_right;
  logic ser_data, chan_sel, atten_n, word_req, underrun;

  int n_cmp = 0;
  int n_bad = 0;
  int feed_idx = 0;
  int feed_lim = 0;
  int wr_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] pat_l(int k);
    if (k == 0) return 16'h8000;
    return 16'((k * 16'h1357) ^ 16'h8001);
  endfunction
  function automatic logic [15:0] pat_r(int k);
    if (k == 0) return 16'h0001;
    return 16'((k * 16'h2468) ^ 16'h7ffe) + 16'(k);
  endfunction

  assign smp_valid = (feed_idx < feed_lim);
  assign smp_left  = pat_l(feed_idx);
  assign smp_right = pat_r(feed_idx);

  always @(posedge clk) begin
    if (rst_n && smp_valid && smp_ready) feed_idx <= feed_idx + 1;
    if (rst_n && word_req) wr_cnt <= wr_cnt + 1;
  end

  sdac_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .tx_en(tx_en),
    .atten_req(atten_req), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .ser_data(ser_data),
    .chan_sel(chan_sel), .atten_n(atten_n), .word_req(word_req),
    .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one 32-bit frame, sampled just before each rising bit-clock edge
  task automatic run_frame(input int dis_at, output logic [15:0] gl,
                           output logic [15:0] gr, output int ws_bad);
    gl = '0; gr = '0; ws_bad = 0;
    for (int b = 0; b < 32; b++) begin
      @(negedge clk) bit_clk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      if (b < 16) gl = {gl[14:0], ser_data};
      else        gr = {gr[14:0], ser_data};
      if (chan_sel !== (b >= 16)) ws_bad++;
      @(negedge clk) bit_clk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (b == dis_at) tx_en = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] gl, gr;
    int wsb, wr0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ser_data", ser_data, 0);
    check("R1 chan_sel", chan_sel, 0);
    check("R1 atten_n", atten_n, 1);
    check("R1 smp_ready", smp_ready, 1);
    check("R1 underrun", underrun, 0);
    check("R1 word_req", word_req, 0);

    // R9 attenuation line
    atten_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 atten low", atten_n, 0);
    atten_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 atten high", atten_n, 1);

    // R5 one pair held, second refused
    feed_lim = 6;
    repeat (4) @(negedge clk);
    check("R5 ready low when full", smp_ready, 0);
    check("R5 one pair taken", feed_idx, 1);

    // R10 R2 R3 R6 streaming frames
    tx_en = 1'b1;
    for (int f = 0; f < 6; f++) begin
      wr0 = wr_cnt;
      run_frame(-1, gl, gr, wsb);
      check("R2 left word", gl, pat_l(f));
      check("R2 right word", gr, pat_r(f));
      check("R3 strobe levels", wsb, 0);
      check("R6 two requests", wr_cnt - wr0, 2);
    end
    check("R7 no underrun yet", underrun, 0);

    // R7 underrun frame
    wr0 = wr_cnt;
    run_frame(-1, gl, gr, wsb);
    check("R7 zero left", gl, 0);
    check("R7 zero right", gr, 0);
    check("R7 flag set", underrun, 1);
    check("R6 requests in underrun", wr_cnt - wr0, 2);

    feed_lim = 9;
    repeat (4) @(negedge clk);
    run_frame(-1, gl, gr, wsb);
    check("R7 resume left", gl, pat_l(6));
    check("R7 resume right", gr, pat_r(6));
    check("R7 flag sticky", underrun, 1);

    // R8 disable mid-frame: frame completes
    run_frame(5, gl, gr, wsb);
    check("R8 finish left", gl, pat_l(7));
    check("R8 finish right", gr, pat_r(7));
    check("R8 finish strobe", wsb, 0);
    wr0 = wr_cnt;
    run_frame(-1, gl, gr, wsb);
    check("R8 idle data", {gl, gr}, 0);
    check("R8 idle strobe low", wsb, 16);
    check("R8 idle no requests", wr_cnt - wr0, 0);
    check("R8 pair still held", smp_ready, 0);
    check("R8 handshakes", feed_idx, 9);

    // R10 restart sends the held pair
    tx_en = 1'b1;
    run_frame(-1, gl, gr, wsb);
    check("R10 restart left", gl, pat_l(8));
    check("R10 restart right", gr, pat_r(8));
    check("R10 restart strobe", wsb, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule